// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is a single output compare channel. It follows one of two free-running timer counts and drives one output pin. A 3-bit mode field selects the pin behaviour. In the edge modes a match against the primary compare value forces the pin high, forces it low, or toggles it. In the pulse modes the pin is high between a primary match and a secondary match, either once or on every timer period. In the PWM modes the pin goes high on each timer period boundary and low at the duty compare.

Both PWM modes reload the duty from the secondary register at every period boundary. One PWM variant also watches an active-low fault pin. When that pin is low, the output is forced low in the same cycle. A sticky fault flag is then set, and it clears only when software writes a different mode.

Software programs the channel through three 16-bit registers: a control word, a primary compare value and a secondary compare value. It observes the pin level, a one-cycle compare event pulse and the read-back control word.

Top module: `oc_channel`

## Requirements
- R1: After reset the control word reads 0, the primary compare reads 0 and the pin and event outputs are low. In the control word only these bits are writable and read back: bit 13 (idle stop), bit 3 (timebase select) and bits 2..0 (mode). Bit 4 is the read-only fault flag, and every other bit reads 0.
- R2: A control write whose mode differs from the current mode sets the pin on the next clock edge: high for mode 010 and low for every other mode. A control write that leaves the mode unchanged does not alter the pin.
- R3: On a primary compare match, mode 001 drives the pin high, mode 010 drives it low and mode 011 toggles it. Each such match raises the event output for exactly that one cycle.
- R4: Bit 3 of the control word chooses the timebase: 0 follows timer A and 1 follows timer B. The timer that is not selected has no effect.
- R5: In modes 100 and 101 the pin rises on a primary match while it is low and falls on a secondary match while it is high, with one event pulse per edge. When both values match in the same cycle, the current pin level decides: a low pin rises and a high pin falls.
- R6: In mode 100, the edge that brings the pin low also sets the mode field to 000. No further edges or events follow.
- R7: In modes 110 and 111, a period strobe from the selected timer copies the secondary value into the primary register. On that strobe the pin goes high if the secondary value is nonzero and low if it is zero, and one event pulse is raised. The pin falls when the count equals the primary value. A period strobe takes precedence over a duty match in the same cycle.
- R8: In mode 111, a low fault input forces the pin low in the same cycle. The fault flag (bit 4) sets on the next edge and holds the pin low with no events. Only a control write with a different mode clears the flag. In mode 110 the fault input has no effect.
- R9: When bit 13 is 1 and the CPU-idle input is high, the channel is frozen: the pin keeps its level and no events occur. When bit 13 is 0 the channel runs during idle.
- R10: In mode 000 the pin stays low and no event is raised, whatever the timer counts or strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_idle | input | 1 | CPU idle indication |
| fault_n | input | 1 | Active-low fault input |
| tmr_a_count | input | 16 | Timer A count |
| tmr_a_period | input | 1 | Timer A period strobe |
| tmr_b_count | input | 16 | Timer B count |
| tmr_b_period | input | 1 | Timer B period strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| pri_we | input | 1 | Primary compare write strobe |
| pri_wdata | input | 16 | Primary compare write data |
| sec_we | input | 1 | Secondary compare write strobe |
| sec_wdata | input | 16 | Secondary compare write data |
| ctl_rdata | output | 16 | Control word read-back, including fault flag |
| pri_rdata | output | 16 | Primary compare read-back |
| pin_out | output | 1 | Compare output pin |
| evt_out | output | 1 | One-cycle compare event pulse |

## Verification
In the pulse modes, a rising edge and a falling edge can both be due in the same cycle once the primary and secondary values are equal. The bench provokes this by setting both values to 5 and running the timer through several periods. It expects the pin to alternate between rising and falling on successive periods, with exactly one event pulse each time. In the PWM modes, the period reload can coincide with a duty match. Duty values from 0 up to beyond the period are swept so that the strobe wins, and each cycle's pin level is compared against the arithmetic expectation "high while count < duty".

// File: rtl/oc_pkg.sv
// Package: shared mode encoding and control word bit positions for the
// output compare channel. Assumes a 16-bit control word.
package oc_pkg;
    typedef enum logic [2:0] {
        OC_OFF         = 3'b000,
        OC_SET_HI      = 3'b001,
        OC_SET_LO      = 3'b010,
        OC_TOGGLE      = 3'b011,
        OC_ONE_PULSE   = 3'b100,
        OC_PULSE_TRAIN = 3'b101,
        OC_PWM         = 3'b110,
        OC_PWM_FLT     = 3'b111
    } oc_mode_e;

    localparam int CTL_W    = 16;
    localparam int TSEL_BIT = 3;
    localparam int FLT_BIT  = 4;
    localparam int SIDL_BIT = 13;
endpackage

// File: rtl/oc_tb_select.sv
// Timebase selector: passes one of two timer count/strobe pairs to the
// compare logic. Assumes both timers share the channel clock.
module oc_tb_select #(
    parameter int W = 16,
    parameter int N_TB = 2
) (
    input  logic [N_TB-1:0][W-1:0] cnt_in,
    input  logic [N_TB-1:0]        per_in,
    input  logic [$clog2(N_TB)-1:0] sel,
    output logic [W-1:0]           cnt,
    output logic                   per
);
    // Select the count and period strobe of the chosen timer.
    always_comb begin
        cnt = cnt_in[sel];
        per = per_in[sel];
    end
endmodule

// File: rtl/oc_fault_guard.sv
// Fault guard: latches a sticky fault flag while in the fault-enabled PWM
// mode and produces a hold that blanks the pin combinationally.
// Assumes fault_n is already synchronised to clk.
module oc_fault_guard
    import oc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  oc_mode_e mode,
    input  logic     fault_n,
    input  logic     mode_chg,
    output logic     flt_q,
    output logic     hold
);
    logic fault_now;

    // Fault is live only in the fault-enabled PWM mode.
    always_comb fault_now = (mode == OC_PWM_FLT) && !fault_n;

    // Sticky flag: cleared only by a mode-changing control write.
    always_ff @(posedge clk) begin
        if (!rst_n)        flt_q <= 1'b0;
        else if (mode_chg) flt_q <= 1'b0;
        else if (fault_now) flt_q <= 1'b1;
    end

    // Hold the pin low as soon as the fault is seen or while it is latched.
    always_comb hold = flt_q || fault_now;

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_q && !mode_chg |=> flt_q);
endmodule

// File: rtl/oc_pin_engine.sv
// Pin engine: per-mode next-state logic for the pin and the event pulse,
// plus the duty reload and one-shot auto-disable requests to the register
// file. Priority: mode change, then fault hold, then idle freeze, then mode.
module oc_pin_engine
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  oc_mode_e     mode,
    input  oc_mode_e     new_mode,
    input  logic         mode_chg,
    input  logic         run,
    input  logic         hold,
    input  logic [W-1:0] cnt,
    input  logic         per,
    input  logic [W-1:0] pri,
    input  logic [W-1:0] sec,
    output logic         pin_q,
    output logic         irq_q,
    output logic         load_duty,
    output logic         auto_off
);
    logic hit_pri, hit_sec, pin_d, irq_d;

    // Compare the selected count against both compare registers.
    always_comb begin
        hit_pri = (cnt == pri);
        hit_sec = (cnt == sec);
    end

    // Next pin level, event and register requests for the current mode.
    always_comb begin
        pin_d     = pin_q;
        irq_d     = 1'b0;
        load_duty = 1'b0;
        auto_off  = 1'b0;
        if (mode_chg) begin
            pin_d = (new_mode == OC_SET_LO);
        end else if (hold) begin
            pin_d = 1'b0;
        end else if (run) begin
            case (mode)
                OC_SET_HI: if (hit_pri) begin pin_d = 1'b1; irq_d = 1'b1; end
                OC_SET_LO: if (hit_pri) begin pin_d = 1'b0; irq_d = 1'b1; end
                OC_TOGGLE: if (hit_pri) begin pin_d = !pin_q; irq_d = 1'b1; end
                OC_ONE_PULSE, OC_PULSE_TRAIN: begin
                    if (!pin_q && hit_pri) begin
                        pin_d = 1'b1;
                        irq_d = 1'b1;
                    end else if (pin_q && hit_sec) begin
                        pin_d    = 1'b0;
                        irq_d    = 1'b1;
                        auto_off = (mode == OC_ONE_PULSE);
                    end
                end
                OC_PWM, OC_PWM_FLT: begin
                    if (per) begin
                        load_duty = 1'b1;
                        pin_d     = (sec != '0);
                        irq_d     = 1'b1;
                    end else if (pin_q && hit_pri) begin
                        pin_d = 1'b0;
                    end
                end
                default: pin_d = 1'b0;
            endcase
        end
    end

    // Register the pin level and the event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            pin_q <= pin_d;
            irq_q <= irq_d;
        end
    end

    p_init_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> pin_q == ($past(new_mode) == OC_SET_LO));
    p_idle_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg && !hold && mode != OC_OFF && !run |=> $stable(pin_q) && !irq_q);
endmodule

// File: rtl/oc_channel.sv
// Output compare channel top: control and compare registers, timebase
// selection, fault guard and pin engine. Register writes take effect on
// the next clock edge; a hardware duty reload wins over a software write
// to the primary register in the same cycle.
module oc_channel
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_idle,
    input  logic         fault_n,
    input  logic [W-1:0] tmr_a_count,
    input  logic         tmr_a_period,
    input  logic [W-1:0] tmr_b_count,
    input  logic         tmr_b_period,
    input  logic         ctl_we,
    input  logic [15:0]  ctl_wdata,
    input  logic         pri_we,
    input  logic [W-1:0] pri_wdata,
    input  logic         sec_we,
    input  logic [W-1:0] sec_wdata,
    output logic [15:0]  ctl_rdata,
    output logic [W-1:0] pri_rdata,
    output logic         pin_out,
    output logic         evt_out
);
    oc_mode_e     mode_q, new_mode;
    logic         tsel_q, sidl_q, flt_q, hold, run, mode_chg;
    logic [W-1:0] pri_q, sec_q, cnt;
    logic         per, pin_q, irq_q, load_duty, auto_off;
    logic         unused_ctl_bits;

    // Decode the written mode and whether it changes the current one.
    always_comb begin
        new_mode        = oc_mode_e'(ctl_wdata[2:0]);
        mode_chg        = ctl_we && (new_mode != mode_q);
        run             = (mode_q != OC_OFF) && !(sidl_q && cpu_idle);
        unused_ctl_bits = ^{ctl_wdata[15:14], ctl_wdata[12:4]};
    end

    // Control register: software write, or one-shot fall-back to disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OC_OFF;
            tsel_q <= 1'b0;
            sidl_q <= 1'b0;
        end else if (ctl_we) begin
            mode_q <= new_mode;
            tsel_q <= ctl_wdata[TSEL_BIT];
            sidl_q <= ctl_wdata[SIDL_BIT];
        end else if (auto_off) begin
            mode_q <= OC_OFF;
        end
    end

    // Compare registers: duty reload takes priority over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '0;
            sec_q <= '0;
        end else begin
            if (load_duty)   pri_q <= sec_q;
            else if (pri_we) pri_q <= pri_wdata;
            if (sec_we)      sec_q <= sec_wdata;
        end
    end

    oc_tb_select #(.W(W), .N_TB(2)) u_tbsel (
        .cnt_in ({tmr_b_count, tmr_a_count}),
        .per_in ({tmr_b_period, tmr_a_period}),
        .sel    (tsel_q),
        .cnt    (cnt),
        .per    (per)
    );

    oc_fault_guard u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_q),
        .fault_n  (fault_n),
        .mode_chg (mode_chg),
        .flt_q    (flt_q),
        .hold     (hold)
    );

    oc_pin_engine #(.W(W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .new_mode  (new_mode),
        .mode_chg  (mode_chg),
        .run       (run),
        .hold      (hold),
        .cnt       (cnt),
        .per       (per),
        .pri       (pri_q),
        .sec       (sec_q),
        .pin_q     (pin_q),
        .irq_q     (irq_q),
        .load_duty (load_duty),
        .auto_off  (auto_off)
    );

    // Drive outputs; the fault hold blanks the pin without waiting a clock.
    always_comb begin
        pin_out   = pin_q && !hold;
        evt_out   = irq_q;
        pri_rdata = pri_q;
        ctl_rdata = {2'b00, sidl_q, 8'h00, flt_q, tsel_q, mode_q};
    end

    p_fault_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == OC_PWM_FLT && !fault_n |-> !pin_out);
    p_oneshot_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_off && !ctl_we |=> mode_q == OC_OFF);
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == OC_OFF && !ctl_we |=> !evt_out && !pin_out);
endmodule

// File: tb/oc_channel_test.sv
`timescale 1ns/1ps
module oc_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_idle = 1'b0, fault_n = 1'b1;
    logic [15:0] tmr_a_count = 16'hFFFF, tmr_b_count = 16'hFFFF;
    logic        tmr_a_period = 1'b0, tmr_b_period = 1'b0;
    logic        ctl_we = 1'b0, pri_we = 1'b0, sec_we = 1'b0;
    logic [15:0] ctl_wdata = '0, pri_wdata = '0, sec_wdata = '0;
    logic [15:0] ctl_rdata, pri_rdata;
    logic        pin_out, evt_out;
    int          nchk = 0, nerr = 0;

    always #2 clk = ~clk;

    oc_channel uut (
        .clk(clk), .rst_n(rst_n), .cpu_idle(cpu_idle), .fault_n(fault_n),
        .tmr_a_count(tmr_a_count), .tmr_a_period(tmr_a_period),
        .tmr_b_count(tmr_b_count), .tmr_b_period(tmr_b_period),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .pri_we(pri_we), .pri_wdata(pri_wdata),
        .sec_we(sec_we), .sec_wdata(sec_wdata),
        .ctl_rdata(ctl_rdata), .pri_rdata(pri_rdata),
        .pin_out(pin_out), .evt_out(evt_out)
    );

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_we = 1'b1; ctl_wdata = v; tick; ctl_we = 1'b0;
    endtask
    task automatic wr_pri(input logic [15:0] v);
        pri_we = 1'b1; pri_wdata = v; tick; pri_we = 1'b0;
    endtask
    task automatic wr_sec(input logic [15:0] v);
        sec_we = 1'b1; sec_wdata = v; tick; sec_we = 1'b0;
    endtask
    task automatic drv_a(input logic [15:0] c, input logic p);
        tmr_a_count = c; tmr_a_period = p;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        int tg;
        logic ep;
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 pri", pri_rdata, 0);
        chk("R1 pin", pin_out, 0);
        chk("R1 evt", evt_out, 0);
        wr_ctl(16'hFFFF);
        chk("R1 readback", ctl_rdata, 16'h200F);
        wr_ctl(16'h0000);
        chk("R1 cleared", ctl_rdata, 0);

        // R2 initial level per mode
        for (int m = 0; m < 8; m++) begin
            wr_ctl(16'(m));
            chk("R2 init level", pin_out, (m == 2));
        end
        wr_ctl(16'h0002);
        chk("R2 mode 010 high", pin_out, 1);
        wr_ctl(16'h000A);
        chk("R2 same mode keeps pin", pin_out, 1);
        wr_ctl(16'h0000);

        // R3 single-edge modes
        wr_pri(16'd5);
        wr_ctl(16'h0001);
        drv_a(16'd4, 1'b0); tick;
        chk("R3 no match pin", pin_out, 0);
        chk("R3 no match evt", evt_out, 0);
        drv_a(16'd5, 1'b0); tick;
        chk("R3 set-high pin", pin_out, 1);
        chk("R3 set-high evt", evt_out, 1);
        drv_a(16'd6, 1'b0); tick;
        chk("R3 evt one cycle", evt_out, 0);
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0002);
        drv_a(16'd5, 1'b0); tick;
        chk("R3 set-low pin", pin_out, 0);
        chk("R3 set-low evt", evt_out, 1);
        drv_a(16'hFFFF, 1'b0);
        wr_pri(16'd2);
        wr_ctl(16'h0003);
        tg = 0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                drv_a(16'(c), 1'b0); tick;
                if (c == 2) tg++;
                chk("R3 toggle pin", pin_out, tg % 2);
                chk("R3 toggle evt", evt_out, (c == 2));
            end
        end

        // R4 timebase select
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0000);
        wr_pri(16'd4);
        wr_ctl(16'h0009);
        drv_a(16'd4, 1'b0); tmr_b_count = 16'd0; tick;
        chk("R4 unselected timer ignored", pin_out, 0);
        chk("R4 unselected evt", evt_out, 0);
        tmr_b_count = 16'd4; tick;
        chk("R4 timer B match", pin_out, 1);
        tmr_b_count = 16'hFFFF; drv_a(16'hFFFF, 1'b0);

        // R5 continuous pulses
        wr_ctl(16'h0000);
        wr_pri(16'd3); wr_sec(16'd9);
        wr_ctl(16'h0005);
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 16; c++) begin
                drv_a(16'(c), 1'b0); tick;
                chk("R5 train pin", pin_out, (c >= 3 && c < 9));
                chk("R5 train evt", evt_out, (c == 3 || c == 9));
            end
        end

        // R6 single pulse then disabled
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0000);
        wr_ctl(16'h0004);
        for (int p = 0; p < 2; p++) begin
            for (int c = 0; c < 16; c++) begin
                drv_a(16'(c), 1'b0); tick;
                chk("R6 one-shot pin", pin_out, (p == 0 && c >= 3 && c < 9));
                chk("R6 one-shot evt", evt_out, (p == 0 && (c == 3 || c == 9)));
                if (p == 0 && c == 9) chk("R6 mode back to 000", ctl_rdata[2:0], 0);
            end
        end

        // R5 collision: primary == secondary
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0000);
        wr_pri(16'd5); wr_sec(16'd5);
        wr_ctl(16'h0005);
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                drv_a(16'(c), 1'b0); tick;
                ep = (p % 2 == 0) ? (c >= 5) : (c < 5);
                chk("R5 collision pin", pin_out, ep);
                chk("R5 collision evt", evt_out, (c == 5));
            end
        end

        // R7 PWM duty sweep, period 8 (strobe at count 7)
        for (int d = 0; d < 10; d++) begin
            drv_a(16'hFFFF, 1'b0);
            wr_ctl(16'h0000);
            wr_sec(16'(d));
            wr_pri(16'h00FF);
            wr_ctl(16'h0006);
            for (int c = 0; c < 8; c++) begin
                drv_a(16'(c), (c == 7)); tick;
            end
            chk("R7 duty reload", pri_rdata, d);
            for (int c = 0; c < 8; c++) begin
                drv_a(16'(c), (c == 7)); tick;
                ep = (c == 7) ? (d != 0) : (d != 0 && c < d);
                chk("R7 pwm pin", pin_out, ep);
                chk("R7 pwm evt", evt_out, (c == 7));
            end
        end

        // R8 fault handling
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0000);
        wr_sec(16'd4);
        wr_ctl(16'h0007);
        for (int c = 0; c < 8; c++) begin
            drv_a(16'(c), (c == 7)); tick;
        end
        drv_a(16'd0, 1'b0); tick;
        chk("R8 pwm running", pin_out, 1);
        fault_n = 1'b0; #1;
        chk("R8 immediate blank", pin_out, 0);
        tick;
        chk("R8 flag set", ctl_rdata[4], 1);
        fault_n = 1'b1;
        for (int c = 0; c < 8; c++) begin
            drv_a(16'(c), (c == 7)); tick;
            chk("R8 held pin", pin_out, 0);
            chk("R8 held evt", evt_out, 0);
        end
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0007);
        chk("R8 same mode keeps flag", ctl_rdata[4], 1);
        wr_ctl(16'h0006);
        chk("R8 mode change clears flag", ctl_rdata[4], 0);
        fault_n = 1'b0;
        for (int c = 0; c < 8; c++) begin
            drv_a(16'(c), (c == 7)); tick;
        end
        drv_a(16'd0, 1'b0); tick;
        chk("R8 mode 110 ignores fault", pin_out, 1);
        chk("R8 mode 110 no flag", ctl_rdata[4], 0);
        fault_n = 1'b1;

        // R9 idle stop
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0000);
        wr_pri(16'd2);
        wr_ctl(16'h2003);
        cpu_idle = 1'b1;
        drv_a(16'd2, 1'b0); tick;
        chk("R9 frozen pin", pin_out, 0);
        chk("R9 frozen evt", evt_out, 0);
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0003);
        drv_a(16'd2, 1'b0); tick;
        chk("R9 runs in idle pin", pin_out, 1);
        chk("R9 runs in idle evt", evt_out, 1);
        cpu_idle = 1'b0;

        // R10 disabled mode
        drv_a(16'hFFFF, 1'b0);
        wr_ctl(16'h0000);
        wr_pri(16'd5);
        for (int c = 0; c < 8; c++) begin
            drv_a(16'(c), 1'b1); tick;
            chk("R10 off pin", pin_out, 0);
            chk("R10 off evt", evt_out, 0);
        end

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule